// File: doc/BRIEF.md
# Serial port DMA address generator

This block holds the transfer parameters for a set of DMA channels that move words between internal memory and the word buffers of several serial ports. Channels come in pairs: channel 2p serves the first buffer of serial port p and channel 2p+1 serves the second. Each channel keeps four values: a start/current index, a signed stride, a remaining word count and a chain pointer. Software loads these through a small register port, then sets the channel's enable bit.

When a serial buffer asks for a word, it raises its request line. If the channel is live, the block acknowledges it and drives that channel's current index on the shared address output. At the end of the cycle the index moves by the stride and the count drops by one. A signed stride lets a buffer be walked upward or downward, and the index wraps modulo 2^ADDR_W. When the last word has been acknowledged, the channel pulses its interrupt line and clears its own enable bit. The chain pointer is only stored and returned on read; nothing here fetches descriptors.

Top module: `sport_dma_addrgen`

## Requirements
- R1: After reset every parameter register and the enable register read as zero, no acknowledge is given, every interrupt line is low and the address output is zero.
- R2: The register offset 0x40+4n holds the index of channel n. Offset 0x41+4n holds its modify, 0x42+4n its count and 0x43+4n its chain pointer. Offset 0x00 is the enable register, with bit n enabling channel n. Index, modify and chain pointer are 19 bits. Count is 16 bits and its upper read bits are zero. Any other offset reads zero. Every written value reads back combinationally on the read data output.
- R3: A request is ignored while the channel's enable bit is clear or its count is zero. No acknowledge is given, and its index and count stay unchanged.
- R4: In the cycle a channel is acknowledged, the address output carries that channel's index. From the next cycle the index equals the old index plus the modify value, with modify read as a 19-bit two's-complement number and the sum wrapped modulo 2^19. The address output is zero when nothing is acknowledged.
- R5: Each acknowledge decreases that channel's count by exactly one.
- R6: The acknowledge that takes a count from 1 to 0 is followed, in the next cycle only, by a one-cycle pulse on that channel's interrupt line. In that same cycle its enable bit reads zero.
- R7: When several live channels request together, only the lowest-numbered one is acknowledged, and at most one acknowledge is high in any cycle.
- R8: If a register write hits the index or count of the channel being acknowledged in the same cycle, the written value wins for that register. The other register still steps. A count write in the final-transfer cycle cancels the interrupt and the self-disable.
- R9: If the enable register is written in the cycle of a channel's final acknowledge, that channel's bit ends up clear whatever value was written. The other bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for write and read |
| reg_wdata | input | 19 | Register write data |
| reg_rdata | output | 19 | Register read data for reg_addr |
| xfer_req | input | 4 | Per-channel word request |
| xfer_ack | output | 4 | Per-channel acknowledge, at most one high |
| xfer_addr | output | 19 | Memory address of the acknowledged word |
| ch_irq | output | 4 | Per-channel completion pulse |

## Verification
Two functions can land in the same clock. One is a register write from software. The other is the per-transfer update of the channel being acknowledged: an index or count write can coincide with the step, and an enable write can coincide with the self-disable. The bench provokes both by holding a channel's request high while writing its index, its count in the final-transfer cycle, and the enable register while the last word is acknowledged. A behavioural model applies the transfer first and then lets the write override it. It compares acknowledge, address, interrupt and read data every cycle.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic [1:0] {
      FLD_INDEX  = 2'd0,
      FLD_MODIFY = 2'd1,
      FLD_COUNT  = 2'd2,
      FLD_CHAIN  = 2'd3
   } sdma_field_e;
endpackage

// File: rtl/sdma_regdec.sv
module sdma_regdec
   import sdma_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int REG_AW   = 8,
   parameter int CH_BASE  = 'h40,
   parameter int CTRL_OFF = 'h00
) (
   input  logic [REG_AW-1:0] addr,
   output logic [NUM_CH-1:0] ch_hit,
   output logic              ctrl_hit,
   output sdma_field_e       fld
);
   localparam int BASE_SLOT = CH_BASE / 4;

   if ((CH_BASE % 4) != 0) begin : g_bad_align
      $error("CH_BASE must be a multiple of four");
   end
   if (CH_BASE + 4 * NUM_CH > (1 << REG_AW)) begin : g_bad_span
      $error("channel registers exceed the register space");
   end
   if (CTRL_OFF >= CH_BASE) begin : g_bad_ctrl
      $error("control offset must lie below the channel block");
   end

   assign fld      = sdma_field_e'(addr[1:0]);
   assign ctrl_hit = (addr == REG_AW'(CTRL_OFF));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
      assign ch_hit[n] = (addr[REG_AW-1:2] == (REG_AW-2)'(BASE_SLOT + n));
   end
endmodule

// File: rtl/sdma_arb.sv
module sdma_arb #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] elig,
   output logic [NUM_CH-1:0] grant
);
   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (elig[i] && !taken) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

   // R7: a single winner per cycle
   p_onehot_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7: nothing eligible below the winner
   p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |-> (((grant - 1'b1) & elig) == '0));

   // R7: some winner whenever anyone is eligible
   p_no_starve_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (elig != '0) |-> (grant != '0));
endmodule

// File: rtl/sdma_chan.sv
module sdma_chan
   import sdma_pkg::*;
#(
   parameter int ADDR_W = 19,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              sel,
   input  sdma_field_e       fld,
   input  logic [DATA_W-1:0] wdata,
   input  logic              en_wr,
   input  logic              en_wbit,
   input  logic              req,
   input  logic              grant,
   output logic              active,
   output logic [ADDR_W-1:0] index,
   output logic [ADDR_W-1:0] modify,
   output logic [CNT_W-1:0]  count,
   output logic [ADDR_W-1:0] chain,
   output logic              enable,
   output logic              irq
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic wr_idx, wr_mod, wr_cnt, wr_chp, done;

   assign wr_idx = wr && sel && (fld == FLD_INDEX);
   assign wr_mod = wr && sel && (fld == FLD_MODIFY);
   assign wr_cnt = wr && sel && (fld == FLD_COUNT);
   assign wr_chp = wr && sel && (fld == FLD_CHAIN);
   assign done   = grant && (count == CNT_ONE) && !wr_cnt;
   assign active = enable && (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         index  <= '0;
         modify <= '0;
         count  <= '0;
         chain  <= '0;
         enable <= 1'b0;
         irq    <= 1'b0;
      end else begin
         irq <= done;
         if (wr_idx)     index <= wdata[ADDR_W-1:0];
         else if (grant) index <= index + modify;
         if (wr_mod)     modify <= wdata[ADDR_W-1:0];
         if (wr_cnt)     count <= wdata[CNT_W-1:0];
         else if (grant) count <= count - CNT_ONE;
         if (wr_chp)     chain <= wdata[ADDR_W-1:0];
         if (done)       enable <= 1'b0;
         else if (en_wr) enable <= en_wbit;
      end
   end

   // R3: an acknowledge needs a live channel and a request
   p_grant_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> (req && enable && (count != '0)));

   // R4: the index moves by the stride on an unopposed transfer
   p_index_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !wr_idx) |=> (index == ADDR_W'($past(index) + $past(modify))));

   // R5: the count drops by one on an unopposed transfer
   p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !wr_cnt) |=> (count == CNT_W'($past(count) - CNT_ONE)));

   // R3: an idle channel keeps its index
   p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant && !wr_idx) |=> $stable(index));

   // R6: the interrupt arrives with the channel already off
   p_irq_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!enable && (count == '0)));

   // R6: the interrupt lasts one cycle
   p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);
endmodule

// File: rtl/sport_dma_addrgen.sv
module sport_dma_addrgen
   import sdma_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ADDR_W   = 19,
   parameter int CNT_W    = 16,
   parameter int REG_AW   = 8,
   parameter int CH_BASE  = 'h40,
   parameter int CTRL_OFF = 'h00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [ADDR_W-1:0]   reg_wdata,
   output logic [ADDR_W-1:0]   reg_rdata,
   input  logic [NUM_CH-1:0]   xfer_req,
   output logic [NUM_CH-1:0]   xfer_ack,
   output logic [ADDR_W-1:0]   xfer_addr,
   output logic [NUM_CH-1:0]   ch_irq
);
   localparam int DATA_W = ADDR_W;

   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("count must fit the register data width");
   end
   if (NUM_CH > DATA_W) begin : g_bad_nch
      $error("enable bits must fit the register data width");
   end
   if (NUM_CH < 1) begin : g_bad_min
      $error("at least one channel is needed");
   end

   logic [NUM_CH-1:0] ch_hit, active, enable, elig;
   logic              ctrl_hit;
   sdma_field_e       fld;
   logic [ADDR_W-1:0] ch_index  [NUM_CH];
   logic [ADDR_W-1:0] ch_modify [NUM_CH];
   logic [ADDR_W-1:0] ch_chain  [NUM_CH];
   logic [CNT_W-1:0]  ch_count  [NUM_CH];

   sdma_regdec #(
      .NUM_CH(NUM_CH), .REG_AW(REG_AW), .CH_BASE(CH_BASE), .CTRL_OFF(CTRL_OFF)
   ) u_dec (
      .addr(reg_addr), .ch_hit(ch_hit), .ctrl_hit(ctrl_hit), .fld(fld)
   );

   assign elig = xfer_req & active;

   sdma_arb #(.NUM_CH(NUM_CH)) u_arb (
      .clk(clk), .rst_n(rst_n), .elig(elig), .grant(xfer_ack)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      sdma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chan (
         .clk(clk), .rst_n(rst_n),
         .wr(reg_wr), .sel(ch_hit[n]), .fld(fld), .wdata(reg_wdata),
         .en_wr(reg_wr && ctrl_hit), .en_wbit(reg_wdata[n]),
         .req(xfer_req[n]), .grant(xfer_ack[n]),
         .active(active[n]),
         .index(ch_index[n]), .modify(ch_modify[n]),
         .count(ch_count[n]), .chain(ch_chain[n]),
         .enable(enable[n]), .irq(ch_irq[n])
      );
   end

   always_comb begin
      xfer_addr = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         xfer_addr = xfer_addr | (ch_index[i] & {ADDR_W{xfer_ack[i]}});
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (ctrl_hit) reg_rdata[NUM_CH-1:0] = enable;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_hit[i]) begin
            case (fld)
               FLD_INDEX:  reg_rdata = ch_index[i];
               FLD_MODIFY: reg_rdata = ch_modify[i];
               FLD_COUNT:  reg_rdata = DATA_W'(ch_count[i]);
               default:    reg_rdata = ch_chain[i];
            endcase
         end
      end
   end

   // R6: a completion pulse only follows an acknowledge of that channel
   p_irq_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_irq != '0) |-> (($past(xfer_ack) & ch_irq) == ch_irq));

   // R4: the address output is quiet without an acknowledge
   p_addr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ack == '0) |-> (xfer_addr == '0));
endmodule

// File: tb/sport_dma_addrgen_tb.sv
module sport_dma_addrgen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [18:0] reg_wdata = '0;
   logic [18:0] reg_rdata;
   logic [3:0]  xfer_req = '0;
   logic [3:0]  xfer_ack;
   logic [18:0] xfer_addr;
   logic [3:0]  ch_irq;

   int vectors = 0;
   int errors  = 0;

   always #10 clk = ~clk;

   sport_dma_addrgen u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
      .xfer_ack(xfer_ack), .xfer_addr(xfer_addr), .ch_irq(ch_irq)
   );

   // behavioural reference
   logic [18:0] m_idx [4];
   logic [18:0] m_mod [4];
   logic [18:0] m_chp [4];
   logic [15:0] m_cnt [4];
   logic [3:0]  m_en, m_irq;

   function automatic int m_grant();
      for (int i = 0; i < 4; i++)
         if (xfer_req[i] && m_en[i] && m_cnt[i] != 16'd0) return i;
      return -1;
   endfunction

   function automatic logic [18:0] m_read(logic [7:0] a);
      int ch;
      if (a == 8'h00) return {15'd0, m_en};
      if (a < 8'h40 || a > 8'h4F) return 19'd0;
      ch = (int'(a) - 'h40) / 4;
      case (a[1:0])
         2'd0:    return m_idx[ch];
         2'd1:    return m_mod[ch];
         2'd2:    return {3'd0, m_cnt[ch]};
         default: return m_chp[ch];
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin
            m_idx[i] = '0; m_mod[i] = '0; m_chp[i] = '0; m_cnt[i] = '0;
         end
         m_en = '0; m_irq = '0;
      end else begin
         int g;
         logic done;
         logic [3:0] nirq;
         g = m_grant();
         done = 1'b0;
         nirq = '0;
         if (g >= 0) begin
            if (!(reg_wr && reg_addr == 8'(8'h40 + 4*g))) m_idx[g] = m_idx[g] + m_mod[g];
            if (!(reg_wr && reg_addr == 8'(8'h42 + 4*g))) begin
               if (m_cnt[g] == 16'd1) begin done = 1'b1; nirq[g] = 1'b1; end
               m_cnt[g] = m_cnt[g] - 16'd1;
            end
         end
         if (reg_wr) begin
            if (reg_addr == 8'h00) m_en = reg_wdata[3:0];
            else if (reg_addr >= 8'h40 && reg_addr <= 8'h4F) begin
               int ch;
               ch = (int'(reg_addr) - 'h40) / 4;
               case (reg_addr[1:0])
                  2'd0:    m_idx[ch] = reg_wdata;
                  2'd1:    m_mod[ch] = reg_wdata;
                  2'd2:    m_cnt[ch] = reg_wdata[15:0];
                  default: m_chp[ch] = reg_wdata;
               endcase
            end
         end
         if (done) m_en[g] = 1'b0;
         m_irq = nirq;
      end
   end

   task automatic step(input string tag);
      int g;
      logic [3:0]  e_ack;
      logic [18:0] e_addr, e_rd;
      #5;
      g = m_grant();
      e_ack  = (g >= 0) ? 4'(1 << g) : 4'd0;
      e_addr = (g >= 0) ? m_idx[g] : 19'd0;
      e_rd   = m_read(reg_addr);
      vectors++;
      if (xfer_ack !== e_ack) begin
         errors++;
         $display("FAIL %s ack: actual %h expected %h", tag, xfer_ack, e_ack);
      end
      if (xfer_addr !== e_addr) begin
         errors++;
         $display("FAIL %s addr: actual %h expected %h", tag, xfer_addr, e_addr);
      end
      if (ch_irq !== m_irq) begin
         errors++;
         $display("FAIL %s irq: actual %h expected %h", tag, ch_irq, m_irq);
      end
      if (reg_rdata !== e_rd) begin
         errors++;
         $display("FAIL %s rdata @%h: actual %h expected %h", tag, reg_addr, reg_rdata, e_rd);
      end
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [18:0] d, input string tag);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step(tag);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      reg_addr = a;
      step(tag);
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) step(tag);
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state over the whole map
      rd(8'h00, "R1");
      for (int a = 'h40; a < 'h50; a++) rd(8'(a), "R1");

      // R2 map, widths, readback
      wr(8'h40, 19'h00100, "R2");
      wr(8'h41, 19'h00004, "R2");
      wr(8'h42, 19'h7ABCD, "R2");
      rd(8'h42, "R2");
      wr(8'h42, 19'h00003, "R2");
      wr(8'h43, 19'h5A5A5, "R2");
      for (int a = 'h40; a < 'h44; a++) rd(8'(a), "R2");
      rd(8'h30, "R2");
      rd(8'h50, "R2");
      rd(8'h01, "R2");

      // R3 request while disabled is ignored
      reg_addr = 8'h40;
      xfer_req = 4'b0001;
      run(3, "R3");
      rd(8'h42, "R3");

      // R4 R5 R6 upward walk to completion
      wr(8'h00, 19'h1, "R4");
      reg_addr = 8'h42;
      run(3, "R5");
      reg_addr = 8'h00;
      run(2, "R6");
      reg_addr = 8'h40;
      run(2, "R3");
      xfer_req = 4'b0000;

      // R4 negative stride with wrap
      wr(8'h44, 19'h00002, "R4");
      wr(8'h45, 19'h7FFFD, "R4");
      wr(8'h46, 19'h00003, "R4");
      wr(8'h00, 19'h2, "R4");
      reg_addr = 8'h44;
      xfer_req = 4'b0010;
      run(5, "R4");
      xfer_req = 4'b0000;

      // R3 enabled but zero count
      wr(8'h00, 19'h1, "R3");
      xfer_req = 4'b0001;
      reg_addr = 8'h40;
      run(2, "R3");
      xfer_req = 4'b0000;

      // R7 all channels contend
      for (int c = 0; c < 4; c++) begin
         wr(8'(8'h40 + 4*c), 19'(19'h1000 * (c + 1)), "R7");
         wr(8'(8'h41 + 4*c), 19'h00001, "R7");
         wr(8'(8'h42 + 4*c), 19'h00002, "R7");
      end
      wr(8'h00, 19'hF, "R7");
      xfer_req = 4'b1111;
      reg_addr = 8'h00;
      run(10, "R7");
      xfer_req = 4'b1010;
      wr(8'h46, 19'h00002, "R7");
      wr(8'h4E, 19'h00002, "R7");
      wr(8'h00, 19'hA, "R7");
      run(6, "R7");
      xfer_req = 4'b0000;

      // R8 index write races a transfer
      wr(8'h48, 19'h00300, "R8");
      wr(8'h49, 19'h00001, "R8");
      wr(8'h4A, 19'h00005, "R8");
      wr(8'h00, 19'h4, "R8");
      xfer_req = 4'b0100;
      wr(8'h48, 19'h00400, "R8");
      rd(8'h48, "R8");
      wr(8'h4A, 19'h00001, "R8");
      wr(8'h4A, 19'h00004, "R8");
      rd(8'h4A, "R8");
      rd(8'h00, "R8");
      run(4, "R8");
      rd(8'h00, "R8");
      xfer_req = 4'b0000;

      // R9 enable write during final transfer
      wr(8'h4C, 19'h00700, "R9");
      wr(8'h4E, 19'h00001, "R9");
      wr(8'h00, 19'h8, "R9");
      xfer_req = 4'b1000;
      wr(8'h00, 19'hF, "R9");
      rd(8'h00, "R9");
      run(2, "R9");
      xfer_req = 4'b0000;

      // R1 reset again clears everything
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd(8'h00, "R1");
      rd(8'h40, "R1");
      rd(8'h4F, "R1");

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule